// File: doc/BRIEF.md
# Command-Macro Sequencer

This block is the control core of a small command-macro processor. A start pulse hands it a first argument word. It then steps a program counter through an external macro program memory, reading one 32-bit word per cycle. Each word is either a branch or a value-producing operation. For a value-producing operation, an external ALU computes a result from the word and the two register operands this block supplies. The block then routes that result, or a parameter word taken from an argument FIFO, to a register, to the method address unit, or out on the method-send interface. Which of these happens is set by a 3-bit assignment mode in the word.

Branches test one register. They can either take one delay slot or jump at once. An exit flag stops the macro after one more instruction, and the stop is reported on `done`. The eight general registers are 32 bits wide, and register 0 is hard-wired to zero. The method address unit holds a 12-bit address and a 6-bit step. Every send uses the current address, and the step is added to the address after each send. A program that runs past its last loaded word also finishes.

Top module: `macro_seq`

## Requirements
- R1: After reset, `done`, `busy`, `sendValid` and `argReady` are all low.
- R2: A `start` pulse clears `done`, sets `busy`, loads register 1 with `startArg`, clears the method address and step, and begins at word 0 on the next cycle. Reads of register 0 return zero, and writes to register 0 are discarded.
- R3: Field positions in a non-branch word are: assignment mode in bits [6:4], destination in [10:8], operand A in [13:11] and operand B in [16:14]. The modes are: 0 writes a fetched parameter. 1 writes the result. 2 writes the result and loads the address from it. 3 writes a fetched parameter and sends it. 4 writes and sends the result. 5 writes a fetched parameter and loads the address from it. 6 writes the result, loads the address from it, then sends a fetched parameter. 7 writes the result, loads the address from it, then sends result bits [17:12] zero-extended.
- R4: An address load takes the address from bits [11:0] and the step from bits [17:12]. A send goes out at the current address (the new one in modes 6 and 7), and afterwards the address becomes address plus step, modulo 4096.
- R5: A word whose bits [2:0] equal 7 is a branch on register A. With bit 4 set it is taken when A is nonzero; with bit 4 clear it is taken when A is zero. The target is PC plus the sign-extended bits [31:14].
- R6: A taken branch with bit 5 clear executes the following word first and then jumps. With bit 5 set, it jumps immediately.
- R7: A word with bit 7 set makes the next word execute, and then the macro stops with `done` high and `busy` low.
- R8: An operation that needs a parameter holds `argReady` high. While `argValid` is low, the operation stalls: the PC holds and nothing is sent.
- R9: When the PC reaches or passes `progLen`, the macro stops with `done` high.
- R10: While idle, no send and no parameter request occurs, and `done` stays high until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a macro run |
| startArg | input | 32 | First argument, loaded into register 1 |
| progLen | input | PC_W+1 | Number of loaded program words |
| imemAddr | output | PC_W | Program counter to macro memory |
| imemData | input | 32 | Instruction word at `imemAddr` |
| argValid | input | 1 | Argument FIFO holds a word |
| argReady | output | 1 | Block takes the argument word this cycle |
| argData | input | 32 | Argument FIFO head word |
| aluInstr | output | 32 | Instruction word for the ALU |
| aluOpA | output | 32 | Register operand A |
| aluOpB | output | 32 | Register operand B |
| aluResult | input | 32 | ALU result for the current word |
| sendValid | output | 1 | Method send strobe |
| sendAddr | output | 12 | Method address of the send |
| sendData | output | 32 | Method data of the send |
| busy | output | 1 | Macro running |
| done | output | 1 | Macro finished |

## Verification
All eight assignment modes run from a single two-word program with the same argument, parameter and result values. That choice makes each mode show up only as a distinct pattern of send addresses, send data and parameter consumption, so two modes cannot be confused. The same branch is run taken with a delay slot, taken without one, and not taken; these three runs differ only in which following words send. A backward counting loop, a step that wraps the address, an empty-FIFO stall and a program without an exit cover the remaining sign, modulo, hold and end-of-program behaviour.

// File: rtl/macro_seq_pkg.sv
package macro_seq_pkg;
  localparam int DATA_W = 32;
  localparam int MADDR_W = 12;
  localparam int STEP_W = 6;
  localparam logic [2:0] OP_BRANCH = 3'd7;

  typedef enum logic [2:0] {
    ASG_FETCH = 3'd0,
    ASG_MOVE = 3'd1,
    ASG_MOVE_ADDR = 3'd2,
    ASG_FETCH_SEND = 3'd3,
    ASG_MOVE_SEND = 3'd4,
    ASG_FETCH_ADDR = 3'd5,
    ASG_MOVE_ADDR_FETCH_SEND = 3'd6,
    ASG_MOVE_ADDR_SEND_HIGH = 3'd7
  } asgMode_e;

  typedef enum logic [1:0] {
    SEND_RESULT = 2'd0,
    SEND_PARAM = 2'd1,
    SEND_HIGH = 2'd2
  } sendSrc_e;

  typedef struct packed {
    logic loadArg;
    logic regWrite;
    logic writeParam;
    logic addrLoad;
    logic addrParam;
    logic send;
    sendSrc_e sendSrc;
  } dpStrobe_t;
endpackage

// File: rtl/macro_seq_ctrl.sv
module macro_seq_ctrl
  import macro_seq_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] opA,
  input  logic [PC_W:0] progLen,
  input  logic argValid,
  output logic argReady,
  output logic [PC_W-1:0] pc,
  output dpStrobe_t strb,
  output logic busy,
  output logic done
);
  logic isBranch, inRange, live, needFetch, stall, exec;
  logic jumpPend, exitPend, inSlot, takeBranch;
  logic [PC_W-1:0] jumpTarget, target;
  asgMode_e mode;
  logic unusedBits;

  assign unusedBits = ^{instr[3], instr[DATA_W-1:14+PC_W], instr[13:8]};
  assign isBranch = (instr[2:0] == OP_BRANCH);
  assign mode = asgMode_e'(instr[6:4]);
  assign inRange = ({1'b0, pc} < progLen);
  assign live = busy && !start && inRange;
  assign needFetch = !isBranch && (mode inside {ASG_FETCH, ASG_FETCH_SEND,
                                                ASG_FETCH_ADDR, ASG_MOVE_ADDR_FETCH_SEND});
  assign stall = live && needFetch && !argValid;
  assign exec = live && !stall;
  assign argReady = live && needFetch;
  assign inSlot = jumpPend || exitPend;
  assign takeBranch = isBranch && !inSlot && (instr[4] ? (opA != '0) : (opA == '0));
  assign target = pc + instr[14 +: PC_W];

  always_comb begin
    strb = '0;
    strb.sendSrc = SEND_RESULT;
    strb.loadArg = start;
    if (exec && !isBranch) begin
      strb.regWrite = 1'b1;
      case (mode)
        ASG_FETCH: strb.writeParam = 1'b1;
        ASG_MOVE: ;
        ASG_MOVE_ADDR: strb.addrLoad = 1'b1;
        ASG_FETCH_SEND: begin
          strb.writeParam = 1'b1;
          strb.send = 1'b1;
          strb.sendSrc = SEND_PARAM;
        end
        ASG_MOVE_SEND: strb.send = 1'b1;
        ASG_FETCH_ADDR: begin
          strb.writeParam = 1'b1;
          strb.addrLoad = 1'b1;
          strb.addrParam = 1'b1;
        end
        ASG_MOVE_ADDR_FETCH_SEND: begin
          strb.addrLoad = 1'b1;
          strb.send = 1'b1;
          strb.sendSrc = SEND_PARAM;
        end
        ASG_MOVE_ADDR_SEND_HIGH: begin
          strb.addrLoad = 1'b1;
          strb.send = 1'b1;
          strb.sendSrc = SEND_HIGH;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      done <= 1'b0;
      pc <= '0;
      jumpPend <= 1'b0;
      exitPend <= 1'b0;
      jumpTarget <= '0;
    end else if (start) begin
      busy <= 1'b1;
      done <= 1'b0;
      pc <= '0;
      jumpPend <= 1'b0;
      exitPend <= 1'b0;
    end else if (busy && !inRange) begin
      busy <= 1'b0;
      done <= 1'b1;
      jumpPend <= 1'b0;
      exitPend <= 1'b0;
    end else if (exec) begin
      if (exitPend) begin
        busy <= 1'b0;
        done <= 1'b1;
        exitPend <= 1'b0;
        jumpPend <= 1'b0;
      end else if (jumpPend) begin
        pc <= jumpTarget;
        jumpPend <= 1'b0;
      end else if (takeBranch) begin
        if (instr[5]) begin
          pc <= target;
        end else begin
          pc <= pc + 1'b1;
          jumpPend <= 1'b1;
          jumpTarget <= target;
        end
      end else begin
        pc <= pc + 1'b1;
        exitPend <= instr[7];
      end
    end
  end
endmodule

// File: rtl/macro_seq_dp.sv
module macro_seq_dp
  import macro_seq_pkg::*;
#(
  parameter int REG_N = 8
) (
  input  logic clk,
  input  logic rstN,
  input  dpStrobe_t strb,
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] startArg,
  input  logic [DATA_W-1:0] argData,
  input  logic [DATA_W-1:0] aluResult,
  output logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] opB,
  output logic [MADDR_W-1:0] sendAddr,
  output logic [DATA_W-1:0] sendData
);
  localparam int IDX_W = $clog2(REG_N);

  logic [DATA_W-1:0] regs [REG_N];
  logic [IDX_W-1:0] dstIdx, aIdx, bIdx;
  logic [DATA_W-1:0] wrData, addrSrc;
  logic [MADDR_W-1:0] methAddr, effAddr;
  logic [STEP_W-1:0] methStep, effStep;
  logic unusedBits;

  assign unusedBits = ^{instr[DATA_W-1:17], instr[7:0]};
  assign dstIdx = instr[8 +: IDX_W];
  assign aIdx = instr[11 +: IDX_W];
  assign bIdx = instr[14 +: IDX_W];
  assign opA = (aIdx == '0) ? '0 : regs[aIdx];
  assign opB = (bIdx == '0) ? '0 : regs[bIdx];
  assign wrData = strb.writeParam ? argData : aluResult;
  assign addrSrc = strb.addrParam ? argData : aluResult;
  assign effAddr = strb.addrLoad ? addrSrc[MADDR_W-1:0] : methAddr;
  assign effStep = strb.addrLoad ? addrSrc[MADDR_W +: STEP_W] : methStep;
  assign sendAddr = effAddr;

  always_comb begin
    case (strb.sendSrc)
      SEND_PARAM: sendData = argData;
      SEND_HIGH: sendData = {{(DATA_W-STEP_W){1'b0}}, aluResult[MADDR_W +: STEP_W]};
      default: sendData = aluResult;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_N; i++) regs[i] <= '0;
      methAddr <= '0;
      methStep <= '0;
    end else if (strb.loadArg) begin
      regs[1] <= startArg;
      methAddr <= '0;
      methStep <= '0;
    end else begin
      if (strb.regWrite && dstIdx != '0) regs[dstIdx] <= wrData;
      if (strb.send) begin
        methAddr <= effAddr + MADDR_W'(effStep);
        methStep <= effStep;
      end else if (strb.addrLoad) begin
        methAddr <= effAddr;
        methStep <= effStep;
      end
    end
  end
endmodule

// File: rtl/macro_seq.sv
module macro_seq
  import macro_seq_pkg::*;
#(
  parameter int PC_W = 8,
  parameter int REG_N = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic [31:0] startArg,
  input  logic [PC_W:0] progLen,
  output logic [PC_W-1:0] imemAddr,
  input  logic [31:0] imemData,
  input  logic argValid,
  output logic argReady,
  input  logic [31:0] argData,
  output logic [31:0] aluInstr,
  output logic [31:0] aluOpA,
  output logic [31:0] aluOpB,
  input  logic [31:0] aluResult,
  output logic sendValid,
  output logic [11:0] sendAddr,
  output logic [31:0] sendData,
  output logic busy,
  output logic done
);
  dpStrobe_t strb;

  assign aluInstr = imemData;
  assign sendValid = strb.send;

  macro_seq_ctrl #(.PC_W(PC_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .instr(imemData), .opA(aluOpA),
    .progLen(progLen), .argValid(argValid), .argReady(argReady), .pc(imemAddr),
    .strb(strb), .busy(busy), .done(done)
  );

  macro_seq_dp #(.REG_N(REG_N)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .instr(imemData), .startArg(startArg),
    .argData(argData), .aluResult(aluResult), .opA(aluOpA), .opB(aluOpB),
    .sendAddr(sendAddr), .sendData(sendData)
  );
endmodule

// File: rtl/macro_seq_chk.sv
module macro_seq_chk #(
  parameter int PC_W = 8
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic [PC_W:0] progLen,
  input logic [PC_W-1:0] imemAddr,
  input logic argValid,
  input logic argReady,
  input logic sendValid,
  input logic busy,
  input logic done
);
  a_r8_stall_holds_pc: assert property (@(posedge clk) disable iff (!rstN)
    (argReady && !argValid && !start) |=> $stable(imemAddr));

  a_r8_stall_no_send: assert property (@(posedge clk) disable iff (!rstN)
    (argReady && !argValid) |-> !sendValid);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sendValid && !argReady));

  a_r10_done_hold: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  a_r9_runoff_stops: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !start && ({1'b0, imemAddr} >= progLen)) |=> (done && !busy));

  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done);
endmodule

bind macro_seq macro_seq_chk #(.PC_W(PC_W)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .progLen(progLen), .imemAddr(imemAddr),
  .argValid(argValid), .argReady(argReady), .sendValid(sendValid),
  .busy(busy), .done(done)
);

// File: tb/macro_seq_tb.sv
module macro_seq_tb_top;
  localparam int PC_W = 8;

  typedef struct packed {
    logic [2:0] mode;
    logic [1:0] n;
    logic [11:0] a0;
    logic [31:0] d0;
    logic [11:0] a1;
    logic [31:0] d1;
    logic pops;
  } vec_t;

  localparam logic [31:0] S = 32'h0000_3105;
  localparam logic [31:0] P = 32'h0000_2040;

  // R3/R4: mode word writes r2 (A=r1, imm 0), exit; slot sends r2
  localparam vec_t MODE_TAB [8] = '{
    '{3'd0, 2'd1, 12'h000, P, 12'h000, 32'h0, 1'b1},
    '{3'd1, 2'd1, 12'h000, S, 12'h000, 32'h0, 1'b0},
    '{3'd2, 2'd1, 12'h105, S, 12'h000, 32'h0, 1'b0},
    '{3'd3, 2'd2, 12'h000, P, 12'h000, P, 1'b1},
    '{3'd4, 2'd2, 12'h000, S, 12'h000, S, 1'b0},
    '{3'd5, 2'd1, 12'h040, P, 12'h000, 32'h0, 1'b1},
    '{3'd6, 2'd2, 12'h105, P, 12'h108, S, 1'b1},
    '{3'd7, 2'd2, 12'h105, 32'h3, 12'h108, S, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [31:0] startArg = '0;
  logic [PC_W:0] progLen = '0;
  logic [PC_W-1:0] imemAddr;
  logic [31:0] imemData;
  logic argValid, argReady;
  logic [31:0] argData;
  logic [31:0] aluInstr, aluOpA, aluOpB, aluResult;
  logic sendValid;
  logic [11:0] sendAddr;
  logic [31:0] sendData;
  logic busy, done;

  logic [31:0] prog [16];
  logic [31:0] argQ [4];
  int head = 0, tail = 0;
  bit argEnable = 1'b1;
  bit popPending = 1'b0;
  int sendCnt = 0;
  logic [11:0] sendA [8];
  logic [31:0] sendD [8];
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  assign imemData = prog[imemAddr[3:0]];
  assign argValid = argEnable && (head < tail);
  assign argData = argQ[head[1:0]];
  assign aluResult = aluOpA + aluOpB + {{17{aluInstr[31]}}, aluInstr[31:17]};

  macro_seq #(.PC_W(PC_W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .startArg(startArg), .progLen(progLen),
    .imemAddr(imemAddr), .imemData(imemData), .argValid(argValid), .argReady(argReady),
    .argData(argData), .aluInstr(aluInstr), .aluOpA(aluOpA), .aluOpB(aluOpB),
    .aluResult(aluResult), .sendValid(sendValid), .sendAddr(sendAddr),
    .sendData(sendData), .busy(busy), .done(done)
  );

  // monitor: sample 1 ns before each rising edge
  always begin
    @(negedge clk);
    if (popPending) head++;
    popPending = 1'b0;
    #1.5;
    if (rstN) begin
      if (argValid && argReady) popPending = 1'b1;
      if (sendValid && sendCnt < 8) begin
        sendA[sendCnt] = sendAddr;
        sendD[sendCnt] = sendData;
      end
      if (sendValid) sendCnt++;
    end
  end

  function automatic logic [31:0] enc(int mode, int dst, int a, int b,
                                      logic [14:0] imm, bit ex);
    return {imm, b[2:0], a[2:0], dst[2:0], ex, mode[2:0], 1'b0, 3'b000};
  endfunction

  function automatic logic [31:0] br(int a, bit nz, bit nd, logic [17:0] off, bit ex);
    return {off, a[2:0], 3'b000, ex, 1'b0, nd, nz, 1'b0, 3'b111};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearProg();
    for (int i = 0; i < 16; i++) prog[i] = enc(4, 0, 0, 0, 15'h0, 1'b1);
  endtask

  task automatic launch(logic [31:0] arg, int len, logic [31:0] param);
    @(negedge clk);
    sendCnt = 0;
    head = 0;
    argQ[0] = param;
    tail = 1;
    startArg = arg;
    progLen = len[PC_W:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(string req);
    int n = 0;
    while (!done && n < 300) begin
      @(negedge clk);
      n++;
    end
    #1;
    chk({req, " done"}, {31'b0, done}, 32'd1);
    chk({req, " busy"}, {31'b0, busy}, 32'd0);
  endtask

  task automatic chkSend(string req, int idx, logic [11:0] a, logic [31:0] d);
    chk({req, " addr"}, {20'b0, sendA[idx]}, {20'b0, a});
    chk({req, " data"}, sendD[idx], d);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) argQ[i] = '0;
    for (int i = 0; i < 8; i++) begin
      sendA[i] = '0;
      sendD[i] = '0;
    end
    clearProg();
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 done", {31'b0, done}, 32'd0);
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 sendValid", {31'b0, sendValid}, 32'd0);
    chk("R1 argReady", {31'b0, argReady}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R3 R4 R7: assignment modes
    for (int v = 0; v < 8; v++) begin
      clearProg();
      prog[0] = enc(MODE_TAB[v].mode, 2, 1, 0, 15'h0, 1'b1);
      prog[1] = enc(4, 0, 2, 0, 15'h0, 1'b0);
      prog[2] = enc(4, 0, 1, 0, 15'h0, 1'b0);
      launch(S, 3, P);
      waitDone($sformatf("R7 mode%0d", v));
      @(negedge clk);
      chk($sformatf("R3 mode%0d sends", v), sendCnt, {30'b0, MODE_TAB[v].n});
      chk($sformatf("R3 mode%0d pops", v), head, {31'b0, MODE_TAB[v].pops});
      chkSend($sformatf("R4 mode%0d send0", v), 0, MODE_TAB[v].a0, MODE_TAB[v].d0);
      if (MODE_TAB[v].n == 2'd2)
        chkSend($sformatf("R4 mode%0d send1", v), 1, MODE_TAB[v].a1, MODE_TAB[v].d1);
    end

    // R2: r0 discards writes and reads zero
    clearProg();
    prog[0] = enc(1, 0, 1, 0, 15'h0, 1'b0);
    prog[1] = enc(4, 3, 0, 0, 15'h0, 1'b1);
    launch(32'hDEAD_BEEF, 2, P);
    waitDone("R2 r0");
    chk("R2 r0 sends", sendCnt, 1);
    chk("R2 r0 value", sendD[0], 32'h0);

    // R5 R6: taken with delay slot
    clearProg();
    prog[0] = br(0, 1'b0, 1'b0, 18'd3, 1'b0);
    prog[1] = enc(4, 0, 1, 0, 15'h0, 1'b0);
    prog[2] = enc(4, 0, 0, 0, 15'd5, 1'b0);
    prog[3] = enc(4, 0, 0, 0, 15'd9, 1'b1);
    launch(32'h11, 4, P);
    waitDone("R6 delay");
    chk("R6 delay sends", sendCnt, 2);
    chk("R6 delay slot", sendD[0], 32'h11);
    chk("R5 delay target", sendD[1], 32'd9);

    // R6: taken without delay slot
    prog[0] = br(0, 1'b0, 1'b1, 18'd3, 1'b0);
    launch(32'h11, 4, P);
    waitDone("R6 nodelay");
    chk("R6 nodelay sends", sendCnt, 1);
    chk("R6 nodelay target", sendD[0], 32'd9);

    // R5: not taken (nonzero test on r0)
    prog[0] = br(0, 1'b1, 1'b0, 18'd3, 1'b0);
    launch(32'h11, 4, P);
    waitDone("R5 nottaken");
    chk("R5 nottaken sends", sendCnt, 3);
    chk("R5 nottaken 2nd", sendD[1], 32'd5);

    // R5: backward loop, negative offset
    clearProg();
    prog[0] = enc(4, 1, 1, 0, 15'h7FFF, 1'b0);
    prog[1] = br(1, 1'b1, 1'b1, 18'h3FFFF, 1'b0);
    prog[2] = enc(4, 0, 0, 0, 15'h77, 1'b1);
    launch(32'd3, 3, P);
    waitDone("R5 loop");
    chk("R5 loop sends", sendCnt, 4);
    chk("R5 loop d0", sendD[0], 32'd2);
    chk("R5 loop d2", sendD[2], 32'd0);
    chk("R5 loop d3", sendD[3], 32'h77);

    // R4: address step wraps modulo 4096
    clearProg();
    prog[0] = enc(2, 0, 1, 0, 15'h0, 1'b0);
    prog[1] = enc(4, 0, 1, 0, 15'h0, 1'b0);
    prog[2] = enc(4, 0, 1, 0, 15'h0, 1'b0);
    launch(32'h0000_3FFE, 3, P);
    waitDone("R4 wrap");
    chk("R4 wrap a0", {20'b0, sendA[0]}, 32'hFFE);
    chk("R4 wrap a1", {20'b0, sendA[1]}, 32'h001);

    // R9 R10: run past end, then idle
    clearProg();
    prog[0] = enc(4, 0, 1, 0, 15'h0, 1'b0);
    launch(32'h55, 1, P);
    waitDone("R9 runoff");
    chk("R9 runoff sends", sendCnt, 1);
    repeat (5) @(negedge clk);
    #1;
    chk("R10 idle done", {31'b0, done}, 32'd1);
    chk("R10 idle sends", sendCnt, 1);

    // R8: stall on empty FIFO
    clearProg();
    prog[0] = enc(3, 2, 0, 0, 15'h0, 1'b1);
    argEnable = 1'b0;
    launch(32'h0, 1, P);
    repeat (6) @(negedge clk);
    #1;
    chk("R8 stall no send", sendCnt, 0);
    chk("R8 stall not done", {31'b0, done}, 32'd0);
    chk("R8 stall argReady", {31'b0, argReady}, 32'd1);
    chk("R8 stall pc", {24'b0, imemAddr}, 32'd0);
    argEnable = 1'b1;
    waitDone("R8 resume");
    chk("R8 resume sends", sendCnt, 1);
    chk("R8 resume data", sendD[0], P);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule